// File: doc/BRIEF.md
# E1 Multiframe Status Flag Register

This block assembles an 8-bit read-only status byte for an E1 framer working with CRC4 multiframes. It records the first service-word bit seen in two particular receive frames, shows the first FAS-word bit when the framer runs in double-frame format, and keeps sticky flags for parity errors and signalling stack slips. These sticky flags clear when the status byte is read.

Two handshake flags tell software when the Sn-bit stacks may be accessed. Each one rises at the start of a CRC4 multiframe in its direction. It drops either when software touches the matching stack or when frame 15 of that multiframe begins, whichever happens first. Every bit is a register that changes only on the rising clock edge, so the byte presented to the processor bus is always clean.

Top module: `e1mf_status_reg`

## Requirements
- R1: With CRC4 mode on, bit 0 shows the service-word first bit captured in receive frame 15 and bit 1 the one captured in receive frame 13; both copy from their capture registers only on a receive multiframe start, one cycle after the strobe.
- R2: While CRC4 mode is off, bits 0 and 1 read 0 from the next clock on, and a receive multiframe start does not load them.
- R3: In double-frame format, bit 2 takes the FAS first bit on each FAS sample strobe; in any other format, bit 2 reads 1 from the next clock on, and FAS samples are ignored.
- R4: Bit 3 sets on a transmit channel parity error only while parity checking is enabled, and sets on any alarm-simulation cycle.
- R5: Bit 4 sets on a transmit or a receive parity error regardless of the parity-check enable, and on any alarm-simulation cycle.
- R6: Bit 5 sets on a stack-update miss only while the signalling stacks are enabled.
- R7: Bits 3, 4 and 5 hold once set and clear on a status read; a set event in the same cycle as the read leaves that bit set.
- R8: Bit 6 sets on a receive multiframe start when CRC4 mode is on, and clears on a receive Sn-stack read or on a receive frame start with frame number 15.
- R9: Bit 7 sets on a transmit multiframe start when CRC4 mode is on, and clears on a transmit Sn-stack write or on a transmit frame start with frame number 15.
- R10: When a set and a clear reach bit 6 or bit 7 in the same cycle, the bit ends up set.
- R11: A synchronous reset leaves the byte at 0x04: bit 2 is 1 and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| crc4_en | input | 1 | CRC4 multiframe mode enable |
| dbl_frame | input | 1 | Double-frame format select |
| par_chk_en | input | 1 | Channel parity check enable |
| sig_stack_en | input | 1 | Signalling stack enable |
| rx_mf_start | input | 1 | Receive multiframe start strobe |
| rx_frame_start | input | 1 | Receive frame start strobe |
| rx_frame_num | input | 4 | Receive frame number, 0 to 15 |
| rx_svc_valid | input | 1 | Receive service-word first bit sample strobe |
| rx_svc_bit | input | 1 | Sampled receive service-word first bit |
| fas_valid | input | 1 | FAS first bit sample strobe |
| fas_bit | input | 1 | Sampled FAS-word first bit |
| tx_mf_start | input | 1 | Transmit multiframe start strobe |
| tx_frame_start | input | 1 | Transmit frame start strobe |
| tx_frame_num | input | 4 | Transmit frame number, 0 to 15 |
| tx_par_err | input | 1 | Transmit channel parity error event |
| rx_par_err | input | 1 | Receive channel parity error event |
| alarm_sim | input | 1 | Alarm simulation active |
| stack_miss | input | 1 | Signalling stack updated before access completed |
| sn_rx_rd | input | 1 | Receive Sn-bit stack read strobe |
| sn_tx_wr | input | 1 | Transmit Sn-bit stack write strobe |
| stat_rd | input | 1 | Status register read strobe |
| status | output | 8 | Status byte |

## Verification
The service-word bits are driven with two complementary frame 13/15 patterns. This shows that the two bit positions are not swapped and that nothing reaches the byte before the multiframe strobe. Each sticky flag is driven by each of its sources on its own, both with and without its enable, which tells the gating of bit 3 apart from the ungated bit 4. The handshake flags are cleared once by access and once by frame 15, and a frame 14 start is used to show that other frames do not clear them. Set and clear are also made to coincide, both for the sticky bits against a status read and for the handshake flags against a stack access.

// File: rtl/e1mf_pkg.sv
package e1mf_pkg;

    localparam int FRAME_W        = 4;
    localparam int SVC_EARLY_FRM  = 13;
    localparam int SVC_LATE_FRM   = 15;
    localparam int SN_CLEAR_FRM   = 15;
    localparam int N_STICKY       = 3;

    typedef struct packed {
        logic tx_sn_ready;
        logic rx_sn_ready;
        logic stack_slip;
        logic glob_par;
        logic tx_par;
        logic fas_first;
        logic svc_early;
        logic svc_late;
    } status_t;

    localparam status_t STATUS_RST = '{fas_first: 1'b1, default: 1'b0};

    function automatic logic frame_is(input logic [FRAME_W-1:0] num, input int which);
        return num == FRAME_W'(which);
    endfunction

endpackage

// File: rtl/e1mf_svc_capture.sv
module e1mf_svc_capture
    import e1mf_pkg::*;
#(
    parameter int FW        = FRAME_W,
    parameter int EARLY_FRM = SVC_EARLY_FRM,
    parameter int LATE_FRM  = SVC_LATE_FRM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          crc4_en,
    input  logic          dbl_frame,
    input  logic          rx_mf_start,
    input  logic [FW-1:0] rx_frame_num,
    input  logic          rx_svc_valid,
    input  logic          rx_svc_bit,
    input  logic          fas_valid,
    input  logic          fas_bit,
    output logic          svc_early,
    output logic          svc_late,
    output logic          fas_first
);
    localparam logic [FW-1:0] EARLY_NUM = FW'(EARLY_FRM);
    localparam logic [FW-1:0] LATE_NUM  = FW'(LATE_FRM);

    logic early_shadow, late_shadow;

    // capture registers for the current multiframe
    always_ff @(posedge clk) begin
        if (rst) begin
            early_shadow <= 1'b0;
            late_shadow  <= 1'b0;
        end else if (rx_svc_valid) begin
            if (rx_frame_num == EARLY_NUM) early_shadow <= rx_svc_bit;
            if (rx_frame_num == LATE_NUM)  late_shadow  <= rx_svc_bit;
        end
    end

    // visible copies, refreshed per multiframe
    always_ff @(posedge clk) begin
        if (rst || !crc4_en) begin
            svc_early <= 1'b0;
            svc_late  <= 1'b0;
        end else if (rx_mf_start) begin
            svc_early <= early_shadow;
            svc_late  <= late_shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dbl_frame) fas_first <= 1'b1;
        else if (fas_valid)    fas_first <= fas_bit;
    end

    AST_SVC_ZERO_NO_CRC: assert property (@(posedge clk) disable iff (rst)
        !crc4_en |=> (!svc_early && !svc_late)); // R2
    AST_FAS_ONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !dbl_frame |=> fas_first); // R3
    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (crc4_en && !rx_mf_start) |=> ($stable(svc_early) && $stable(svc_late))); // R1

endmodule

// File: rtl/e1mf_sticky_bits.sv
module e1mf_sticky_bits
    import e1mf_pkg::*;
#(
    parameter int N = N_STICKY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         rd_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            flags[i] <= 1'b0;
            else if (set_ev[i]) flags[i] <= 1'b1;
            else if (rd_clr)    flags[i] <= 1'b0;
        end

        AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> flags[i]); // R7
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!set_ev[i] && !rd_clr) |=> $stable(flags[i])); // R7
        AST_STICKY_CLR: assert property (@(posedge clk) disable iff (rst)
            (!set_ev[i] && rd_clr) |=> !flags[i]); // R7
    end
endmodule

// File: rtl/e1mf_sn_flag.sv
module e1mf_sn_flag
    import e1mf_pkg::*;
#(
    parameter int FW        = FRAME_W,
    parameter int CLEAR_FRM = SN_CLEAR_FRM
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          crc4_en,
    input  logic          mf_start,
    input  logic          frame_start,
    input  logic [FW-1:0] frame_num,
    input  logic          access,
    output logic          ready
);
    logic set_c, clr_c;

    assign set_c = mf_start && crc4_en;
    assign clr_c = access || (frame_start && frame_is(frame_num, CLEAR_FRM));

    always_ff @(posedge clk) begin
        if (rst)        ready <= 1'b0;
        else if (set_c) ready <= 1'b1;
        else if (clr_c) ready <= 1'b0;
    end

    AST_SN_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (mf_start && crc4_en) |=> ready); // R10
    AST_SN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!mf_start && access) |=> !ready); // R8
    AST_SN_NO_CRC_NO_RISE: assert property (@(posedge clk) disable iff (rst)
        (!crc4_en && !ready) |=> !ready); // R8
endmodule

// File: rtl/e1mf_status_reg.sv
module e1mf_status_reg
    import e1mf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               crc4_en,
    input  logic               dbl_frame,
    input  logic               par_chk_en,
    input  logic               sig_stack_en,
    input  logic               rx_mf_start,
    input  logic               rx_frame_start,
    input  logic [FRAME_W-1:0] rx_frame_num,
    input  logic               rx_svc_valid,
    input  logic               rx_svc_bit,
    input  logic               fas_valid,
    input  logic               fas_bit,
    input  logic               tx_mf_start,
    input  logic               tx_frame_start,
    input  logic [FRAME_W-1:0] tx_frame_num,
    input  logic               tx_par_err,
    input  logic               rx_par_err,
    input  logic               alarm_sim,
    input  logic               stack_miss,
    input  logic               sn_rx_rd,
    input  logic               sn_tx_wr,
    input  logic               stat_rd,
    output logic [7:0]         status
);
    status_t             st;
    logic [N_STICKY-1:0] sticky_set, sticky_q;

    e1mf_svc_capture u_svc (
        .clk, .rst, .crc4_en, .dbl_frame, .rx_mf_start, .rx_frame_num,
        .rx_svc_valid, .rx_svc_bit, .fas_valid, .fas_bit,
        .svc_early (st.svc_early),
        .svc_late  (st.svc_late),
        .fas_first (st.fas_first)
    );

    // sticky order: [0] transmit parity, [1] global parity, [2] stack slip
    assign sticky_set[0] = (tx_par_err && par_chk_en) || alarm_sim;
    assign sticky_set[1] = tx_par_err || rx_par_err || alarm_sim;
    assign sticky_set[2] = stack_miss && sig_stack_en;

    e1mf_sticky_bits #(.N(N_STICKY)) u_sticky (
        .clk, .rst,
        .set_ev (sticky_set),
        .rd_clr (stat_rd),
        .flags  (sticky_q)
    );

    assign st.tx_par     = sticky_q[0];
    assign st.glob_par   = sticky_q[1];
    assign st.stack_slip = sticky_q[2];

    e1mf_sn_flag u_rx_sn (
        .clk, .rst, .crc4_en,
        .mf_start    (rx_mf_start),
        .frame_start (rx_frame_start),
        .frame_num   (rx_frame_num),
        .access      (sn_rx_rd),
        .ready       (st.rx_sn_ready)
    );

    e1mf_sn_flag u_tx_sn (
        .clk, .rst, .crc4_en,
        .mf_start    (tx_mf_start),
        .frame_start (tx_frame_start),
        .frame_num   (tx_frame_num),
        .access      (sn_tx_wr),
        .ready       (st.tx_sn_ready)
    );

    assign status = st;

    AST_RESET_VALUE: assert property (@(posedge clk)
        rst |=> (status == STATUS_RST)); // R11
    AST_PARCHK_GATE: assert property (@(posedge clk) disable iff (rst)
        (!par_chk_en && !alarm_sim && !status[3]) |=> !status[3]); // R4
    AST_SLIP_GATE: assert property (@(posedge clk) disable iff (rst)
        (!sig_stack_en && !status[5]) |=> !status[5]); // R6
    AST_GLOBAL_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_par_err || tx_par_err) |=> status[4]); // R5
endmodule

// File: tb/e1mf_status_reg_test.sv
module e1mf_status_reg_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       crc4_en, dbl_frame, par_chk_en, sig_stack_en;
    logic       rx_mf_start, rx_frame_start, rx_svc_valid, rx_svc_bit;
    logic [3:0] rx_frame_num, tx_frame_num;
    logic       fas_valid, fas_bit, tx_mf_start, tx_frame_start;
    logic       tx_par_err, rx_par_err, alarm_sim, stack_miss;
    logic       sn_rx_rd, sn_tx_wr, stat_rd;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    e1mf_status_reg uut (.*);

    task automatic clear_strobes();
        rx_mf_start = 0; rx_frame_start = 0; rx_svc_valid = 0; rx_svc_bit = 0;
        fas_valid = 0; fas_bit = 0; tx_mf_start = 0; tx_frame_start = 0;
        tx_par_err = 0; rx_par_err = 0; alarm_sim = 0; stack_miss = 0;
        sn_rx_rd = 0; sn_tx_wr = 0; stat_rd = 0;
        rx_frame_num = 0; tx_frame_num = 0;
    endtask

    // apply current inputs across one rising edge, then drop strobes
    task automatic tick();
        @(posedge clk);
        #2;
        clear_strobes();
    endtask

    task automatic check(input string req, input logic [7:0] mask, input logic [7:0] exp);
        checks++;
        if ((status & mask) !== (exp & mask)) begin
            fails++;
            $display("FAIL %s: status=%02h expected=%02h (mask %02h)", req, status, exp, mask);
        end
    endtask

    task automatic read_clear();
        stat_rd = 1; tick();
    endtask

    task automatic t_reset();
        rst = 1; tick(); tick();
        check("R11 reset", 8'hFF, 8'h04);
        rst = 0;
    endtask

    task automatic t_service_bits();
        crc4_en = 1;
        rx_svc_valid = 1; rx_frame_num = 13; rx_svc_bit = 1; tick();
        rx_svc_valid = 1; rx_frame_num = 15; rx_svc_bit = 0; tick();
        check("R1 no load before mf start", 8'h03, 8'h00);
        rx_mf_start = 1; tick();
        check("R1 pattern A", 8'h03, 8'h02);
        rx_svc_valid = 1; rx_frame_num = 13; rx_svc_bit = 0; tick();
        rx_svc_valid = 1; rx_frame_num = 15; rx_svc_bit = 1; tick();
        check("R1 hold until mf start", 8'h03, 8'h02);
        rx_mf_start = 1; tick();
        check("R1 pattern B", 8'h03, 8'h01);
        sn_rx_rd = 1; tick();
        crc4_en = 0; tick();
        check("R2 crc4 off zeroes", 8'h03, 8'h00);
        rx_mf_start = 1; tick();
        check("R2 mf start ignored, R8 no rise", 8'hC3, 8'h00);
        crc4_en = 1;
    endtask

    task automatic t_fas();
        dbl_frame = 1; fas_valid = 1; fas_bit = 0; tick();
        check("R3 dbl frame fas 0", 8'h04, 8'h00);
        fas_valid = 1; fas_bit = 1; tick();
        check("R3 dbl frame fas 1", 8'h04, 8'h04);
        fas_valid = 1; fas_bit = 0; tick();
        dbl_frame = 0; fas_valid = 1; fas_bit = 0; tick();
        check("R3 other format reads 1", 8'h04, 8'h04);
    endtask

    task automatic t_parity();
        par_chk_en = 0; tx_par_err = 1; tick();
        check("R4 gated off / R5 global set", 8'h18, 8'h10);
        read_clear();
        check("R7 read clears", 8'h38, 8'h00);
        par_chk_en = 1; tx_par_err = 1; tick();
        check("R4 tx parity set", 8'h18, 8'h18);
        tick();
        check("R7 sticky hold", 8'h18, 8'h18);
        read_clear();
        rx_par_err = 1; tick();
        check("R5 rx parity only global", 8'h18, 8'h10);
        read_clear();
        par_chk_en = 0; alarm_sim = 1; tick();
        check("R4 R5 alarm sim", 8'h18, 8'h18);
        stat_rd = 1; rx_par_err = 1; tick();
        check("R7 set wins over read", 8'h18, 8'h10);
        read_clear();
        check("R7 cleared", 8'h18, 8'h00);
    endtask

    task automatic t_slip();
        sig_stack_en = 0; stack_miss = 1; tick();
        check("R6 miss ignored when disabled", 8'h20, 8'h00);
        sig_stack_en = 1; stack_miss = 1; tick();
        check("R6 miss sets", 8'h20, 8'h20);
        read_clear();
        check("R7 slip cleared", 8'h20, 8'h00);
    endtask

    task automatic t_rx_flag();
        rx_mf_start = 1; tick();
        check("R8 rx flag set", 8'h40, 8'h40);
        rx_frame_start = 1; rx_frame_num = 14; tick();
        check("R8 frame 14 keeps", 8'h40, 8'h40);
        rx_frame_start = 1; rx_frame_num = 15; tick();
        check("R8 frame 15 clears", 8'h40, 8'h00);
        rx_mf_start = 1; tick();
        sn_rx_rd = 1; tick();
        check("R8 stack read clears", 8'h40, 8'h00);
        rx_mf_start = 1; sn_rx_rd = 1; tick();
        check("R10 rx set wins", 8'h40, 8'h40);
    endtask

    task automatic t_tx_flag();
        tx_mf_start = 1; tick();
        check("R9 tx flag set", 8'h80, 8'h80);
        sn_rx_rd = 1; tick();
        check("R9 rx read leaves tx", 8'hC0, 8'h80);
        tx_frame_start = 1; tx_frame_num = 15; tick();
        check("R9 frame 15 clears", 8'h80, 8'h00);
        tx_mf_start = 1; tick();
        sn_tx_wr = 1; tick();
        check("R9 stack write clears", 8'h80, 8'h00);
        tx_mf_start = 1; tx_frame_start = 1; tx_frame_num = 15; tick();
        check("R10 tx set wins", 8'h80, 8'h80);
    endtask

    initial begin
        clear_strobes();
        crc4_en = 0; dbl_frame = 0; par_chk_en = 0; sig_stack_en = 0;
        rst = 1;
        #2;
        t_reset();
        t_service_bits();
        t_fas();
        t_parity();
        t_slip();
        t_rx_flag();
        t_tx_flag();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule